// File: doc/BRIEF.md
# Galloping-Pattern Read Tester

This block drives a small read-only memory through a galloping read sequence and compares each returned word with its expected value. One word serves as the base. The block reads the base and then alternates between each higher word and the base. After the top word it reads the base once more and moves the base up by one. This repeats until every word has served as the base. Each word is therefore read next to every other word, so faults in the decoder and faults that depend on the word read just before show up.

The block owns the memory's address bus and its active-low chip enable, and it reads the returned data word. The surrounding logic supplies the expected word for whatever address is currently driven, on a compare port. A start pulse launches a pass. A busy flag covers the whole pass, and a one-cycle done pulse ends it. The block keeps a pass flag, a record of the first failing address with its expected and observed data, and a count of completed reads. An input selects whether the first mismatch aborts the pass or lets it run to the end.

The sequencer has six states:
- IDLE waits for start.
- OPEN performs the opening read of the base.
- PARTNER reads the current higher word.
- RETURN reads the base again after a partner.
- CLOSE performs the closing read of the base.
- FINISH raises done for one cycle and then goes back to IDLE.

The transitions are:
- IDLE to OPEN when start is high.
- OPEN to PARTNER, or to CLOSE when the base is the top word.
- PARTNER to RETURN.
- RETURN to PARTNER with the next higher partner, or to CLOSE once the partner is the top word.
- CLOSE to OPEN with the next base, or to FINISH after the top base.
- Any read state to FINISH on an aborting mismatch.

Top module: `gp_tester`

## Requirements
- R1: After a synchronous reset the block is idle: busy=0, done=0, mem_ce_n=1, mem_addr=0, read_count=0, pass_ok=1, and all three failure record fields are 0.
- R2: For n=2^ADDR_W words the read order for base b (b going 0,1,...,n-1) is: b, then the pair (j, b) for each j from b+1 up to n-1, then b once more. Base 0 therefore starts 0,1,0,2,0,...
- R3: Each read holds mem_addr steady with mem_ce_n low for exactly READ_CYC consecutive clock cycles. The data is sampled in the last of those cycles.
- R4: A pass that runs to completion makes exactly n*n+n reads, and read_count equals that value while done is high.
- R5: A start pulse taken while idle begins a pass. Busy is high from the next cycle through the done cycle, which is reads*READ_CYC+1 cycles in all. Done is a single-cycle pulse. A start that arrives while busy is ignored.
- R6: All DATA_W bits of every sampled read are compared with exp_data. pass_ok is 0 at done if any bit of any read differed, and 1 otherwise.
- R7: The first mismatching read latches its address into fail_addr, its expected word into fail_exp and its observed word into fail_got. Later mismatches in the same pass leave these fields unchanged.
- R8: With stop_on_err=1, a mismatching read ends the pass: FINISH follows in the next cycle, and read_count includes the failing read.
- R9: With stop_on_err=0, mismatches do not shorten the pass, and read_count at done is n*n+n.
- R10: mem_ce_n is high whenever no read is in progress, which covers IDLE and FINISH.
- R11: Accepting a new start clears read_count, pass_ok (back to 1) and the failure record (back to 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that launches a pass when idle |
| stop_on_err | input | 1 | 1: abort on first mismatch; 0: run the full pass |
| mem_addr | output | ADDR_W | Address driven to the memory |
| mem_ce_n | output | 1 | Active-low chip enable for the memory |
| mem_data | input | DATA_W | Data word returned by the memory |
| exp_data | input | DATA_W | Expected word for the address now driven |
| busy | output | 1 | High while a pass is in progress |
| done | output | 1 | One-cycle pulse ending a pass |
| pass_ok | output | 1 | 1 while no mismatch has been seen in this pass |
| fail_addr | output | ADDR_W | Address of the first mismatch |
| fail_exp | output | DATA_W | Expected word at the first mismatch |
| fail_got | output | DATA_W | Observed word at the first mismatch |
| read_count | output | COUNT_W | Completed reads in the current pass |

## Verification
The bench uses an 8-word, 3-cycle-read configuration and computes the full galloping order itself. It checks every read of every pass against that order and checks the hold length of each read. Fault-free passes, with and without abort, establish the full read count and the busy length, and show that a start during a pass is ignored. Single faults on a partner word, on the top word and on word 0 tell apart a correct first-appearance order from a walk that is off by one or visits words in the wrong order. Abort counts such as 1, 8 and 14 depend directly on where each word first appears. A two-fault pass, whose faulty words appear in the opposite order to their numbering, shows whether the record keeps the first mismatch rather than the last. A clean pass after a failing one shows that the record is cleared.

// File: rtl/gp_pkg.sv
package gp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPEN,
        ST_PARTNER,
        ST_RETURN,
        ST_CLOSE,
        ST_FINISH
    } gp_state_e;

    // Width able to hold n*n+n reads for n = 2**aw words.
    function automatic int gp_count_width(input int aw);
        longint n;
        n = longint'(1) << aw;
        return $clog2(n * n + n + 1);
    endfunction

endpackage

// File: rtl/gp_pace.sv
module gp_pace #(
    parameter int READ_CYC = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    output logic sample
);

    generate
        if (READ_CYC <= 1) begin : g_single
            // One-cycle reads: every active cycle is a sample cycle.
            assign sample = active;
        end else begin : g_multi
            localparam int TW = $clog2(READ_CYC);
            localparam logic [TW-1:0] LAST_TICK = TW'(READ_CYC - 1);

            logic [TW-1:0] tick;

            always_ff @(posedge clk) begin
                if (rst || !active) begin
                    tick <= '0;
                end else if (tick == LAST_TICK) begin
                    tick <= '0;
                end else begin
                    tick <= tick + 1'b1;
                end
            end

            assign sample = active && (tick == LAST_TICK);
        end
    endgenerate

endmodule

// File: rtl/gp_seq.sv
module gp_seq
    import gp_pkg::*;
#(
    parameter int ADDR_W = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              adv,
    input  logic              halt,
    output logic [ADDR_W-1:0] addr,
    output logic              ce_n,
    output logic              active,
    output logic              busy,
    output logic              done,
    output logic              launch
);

    localparam logic [ADDR_W-1:0] TOP = {ADDR_W{1'b1}};

    gp_state_e         state, state_nxt;
    logic [ADDR_W-1:0] base, base_nxt;
    logic [ADDR_W-1:0] partner, partner_nxt;

    // Next-state and counter update.
    always_comb begin
        state_nxt   = state;
        base_nxt    = base;
        partner_nxt = partner;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    state_nxt   = ST_OPEN;
                    base_nxt    = '0;
                    partner_nxt = '0;
                end
            end
            ST_OPEN: begin
                if (adv) begin
                    if (halt) begin
                        state_nxt = ST_FINISH;
                    end else if (base == TOP) begin
                        state_nxt = ST_CLOSE;
                    end else begin
                        partner_nxt = base + 1'b1;
                        state_nxt   = ST_PARTNER;
                    end
                end
            end
            ST_PARTNER: begin
                if (adv) begin
                    state_nxt = halt ? ST_FINISH : ST_RETURN;
                end
            end
            ST_RETURN: begin
                if (adv) begin
                    if (halt) begin
                        state_nxt = ST_FINISH;
                    end else if (partner == TOP) begin
                        state_nxt = ST_CLOSE;
                    end else begin
                        partner_nxt = partner + 1'b1;
                        state_nxt   = ST_PARTNER;
                    end
                end
            end
            ST_CLOSE: begin
                if (adv) begin
                    if (halt || base == TOP) begin
                        state_nxt = ST_FINISH;
                    end else begin
                        base_nxt  = base + 1'b1;
                        state_nxt = ST_OPEN;
                    end
                end
            end
            ST_FINISH: begin
                state_nxt = ST_IDLE;
            end
            default: begin
                state_nxt = ST_IDLE;
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            base    <= '0;
            partner <= '0;
        end else begin
            state   <= state_nxt;
            base    <= base_nxt;
            partner <= partner_nxt;
        end
    end

    // Outputs.
    always_comb begin
        addr   = base;
        active = 1'b0;
        busy   = 1'b1;
        done   = 1'b0;
        unique case (state)
            ST_IDLE:    busy = 1'b0;
            ST_OPEN:    active = 1'b1;
            ST_PARTNER: begin
                active = 1'b1;
                addr   = partner;
            end
            ST_RETURN:  active = 1'b1;
            ST_CLOSE:   active = 1'b1;
            ST_FINISH:  done = 1'b1;
            default:    busy = 1'b0;
        endcase
        ce_n   = ~active;
        launch = start && (state == ST_IDLE);
    end

    // R2: a partner read always targets a word above the base.
    a_r2_partner_above: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PARTNER) |-> (partner > base));

    // R2: the next partner after a base return is the following word.
    a_r2_partner_step: assert property (@(posedge clk) disable iff (rst)
        ($past(state) == ST_RETURN && state == ST_PARTNER) |->
            (partner == $past(partner) + 1'b1));

endmodule

// File: rtl/gp_judge.sv
module gp_judge #(
    parameter int ADDR_W  = 9,
    parameter int DATA_W  = 4,
    parameter int COUNT_W = 19
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               clear,
    input  logic               sample,
    input  logic               stop_on_err,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  exp_word,
    input  logic [DATA_W-1:0]  got_word,
    output logic               halt,
    output logic               pass_ok,
    output logic [ADDR_W-1:0]  fail_addr,
    output logic [DATA_W-1:0]  fail_exp,
    output logic [DATA_W-1:0]  fail_got,
    output logic [COUNT_W-1:0] read_count
);

    logic [DATA_W-1:0] bit_diff;
    logic              mismatch;
    logic              err_seen;

    // Per-bit comparison of the returned word.
    generate
        for (genvar i = 0; i < DATA_W; i++) begin : g_bit
            assign bit_diff[i] = exp_word[i] ^ got_word[i];
        end
    endgenerate

    assign mismatch = sample && (|bit_diff);
    assign halt     = mismatch && stop_on_err;
    assign pass_ok  = ~err_seen;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            read_count <= '0;
            err_seen   <= 1'b0;
            fail_addr  <= '0;
            fail_exp   <= '0;
            fail_got   <= '0;
        end else if (sample) begin
            read_count <= read_count + 1'b1;
            if (mismatch && !err_seen) begin
                err_seen  <= 1'b1;
                fail_addr <= addr;
                fail_exp  <= exp_word;
                fail_got  <= got_word;
            end
        end
    end

    // R7: once a failure is recorded it holds until the next pass clears it.
    a_r7_first_hold: assert property (@(posedge clk) disable iff (rst)
        (err_seen && !clear) |=>
            ($stable(fail_addr) && $stable(fail_exp) && $stable(fail_got)));

endmodule

// File: rtl/gp_tester.sv
module gp_tester
    import gp_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int DATA_W   = 4,
    parameter int READ_CYC = 2,
    parameter int COUNT_W  = gp_count_width(ADDR_W)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic               stop_on_err,
    output logic [ADDR_W-1:0]  mem_addr,
    output logic               mem_ce_n,
    input  logic [DATA_W-1:0]  mem_data,
    input  logic [DATA_W-1:0]  exp_data,
    output logic               busy,
    output logic               done,
    output logic               pass_ok,
    output logic [ADDR_W-1:0]  fail_addr,
    output logic [DATA_W-1:0]  fail_exp,
    output logic [DATA_W-1:0]  fail_got,
    output logic [COUNT_W-1:0] read_count
);

    localparam longint WORDS = longint'(1) << ADDR_W;
    localparam longint TOTAL = WORDS * WORDS + WORDS;

    logic active;
    logic sample;
    logic halt;
    logic launch;

    gp_pace #(
        .READ_CYC (READ_CYC)
    ) u_pace (
        .clk    (clk),
        .rst    (rst),
        .active (active),
        .sample (sample)
    );

    gp_seq #(
        .ADDR_W (ADDR_W)
    ) u_seq (
        .clk    (clk),
        .rst    (rst),
        .start  (start),
        .adv    (sample),
        .halt   (halt),
        .addr   (mem_addr),
        .ce_n   (mem_ce_n),
        .active (active),
        .busy   (busy),
        .done   (done),
        .launch (launch)
    );

    gp_judge #(
        .ADDR_W  (ADDR_W),
        .DATA_W  (DATA_W),
        .COUNT_W (COUNT_W)
    ) u_judge (
        .clk         (clk),
        .rst         (rst),
        .clear       (launch),
        .sample      (sample),
        .stop_on_err (stop_on_err),
        .addr        (mem_addr),
        .exp_word    (exp_data),
        .got_word    (mem_data),
        .halt        (halt),
        .pass_ok     (pass_ok),
        .fail_addr   (fail_addr),
        .fail_exp    (fail_exp),
        .fail_got    (fail_got),
        .read_count  (read_count)
    );

    // R4: an error-free pass always ends on the full read count.
    a_r4_full_count: assert property (@(posedge clk) disable iff (rst)
        (done && pass_ok) |-> (read_count == COUNT_W'(TOTAL)));

    // R3: the address does not move inside a read.
    a_r3_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (!mem_ce_n && !sample) |=> $stable(mem_addr));

    // R10: chip enable is inactive outside a pass.
    a_r10_ce_idle: assert property (@(posedge clk) disable iff (rst)
        (!busy || done) |-> mem_ce_n);

    // R5: done lasts a single cycle.
    a_r5_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

endmodule

// File: tb/gp_tester_bench.sv
module gp_tester_bench;

    localparam int AW    = 3;
    localparam int DW    = 4;
    localparam int RC    = 3;
    localparam int N     = 1 << AW;
    localparam int TOTAL = N * N + N;
    localparam int CW    = gp_pkg::gp_count_width(AW);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic          stop_on_err = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_ce_n;
    logic [DW-1:0] mem_data;
    logic [DW-1:0] exp_data;
    logic          busy, done, pass_ok;
    logic [AW-1:0] fail_addr;
    logic [DW-1:0] fail_exp, fail_got;
    logic [CW-1:0] read_count;

    int errors = 0;
    int checks = 0;
    int cyc = 0;

    int fa_a = -1;
    int fa_b = -1;
    logic [DW-1:0] fm_a = '0;
    logic [DW-1:0] fm_b = '0;

    int exp_seq [TOTAL];

    always #4 clk = ~clk;

    gp_tester #(
        .ADDR_W   (AW),
        .DATA_W   (DW),
        .READ_CYC (RC)
    ) u_gp_tester (
        .clk         (clk),
        .rst         (rst),
        .start       (start),
        .stop_on_err (stop_on_err),
        .mem_addr    (mem_addr),
        .mem_ce_n    (mem_ce_n),
        .mem_data    (mem_data),
        .exp_data    (exp_data),
        .busy        (busy),
        .done        (done),
        .pass_ok     (pass_ok),
        .fail_addr   (fail_addr),
        .fail_exp    (fail_exp),
        .fail_got    (fail_got),
        .read_count  (read_count)
    );

    function automatic logic [DW-1:0] rom(input int a);
        return DW'(a * 5 + 3);
    endfunction

    // Memory model: programmed content plus injected faults, undriven as all-ones.
    always_comb begin
        exp_data = rom(int'(mem_addr));
        mem_data = rom(int'(mem_addr));
        if (int'(mem_addr) == fa_a) mem_data = mem_data ^ fm_a;
        if (int'(mem_addr) == fa_b) mem_data = mem_data ^ fm_b;
        if (mem_ce_n) mem_data = '1;
    end

    // Read monitor.
    logic          mon_en = 1'b0;
    int            mon_idx, mon_tick, seq_bad, busy_cnt, done_cnt;
    logic [AW-1:0] held;

    always @(negedge clk) begin
        if (mon_en) begin
            if (busy) busy_cnt++;
            if (done) done_cnt++;
            if (!mem_ce_n) begin
                if (mon_tick == 0) begin
                    if (mon_idx >= TOTAL || int'(mem_addr) != exp_seq[mon_idx]) seq_bad++;
                    held = mem_addr;
                end else if (mem_addr != held) begin
                    seq_bad++;
                end
                mon_tick++;
                if (mon_tick == RC) begin
                    mon_tick = 0;
                    mon_idx++;
                end
            end else if (mon_tick != 0) begin
                seq_bad++;
            end
        end
    end

    task automatic chk(input string req, input string what, input longint got, input longint expv);
        checks++;
        if (got !== expv) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, expv);
        end
    endtask

    function automatic int first_idx(input int a);
        for (int i = 0; i < TOTAL; i++) begin
            if (exp_seq[i] == a) return i;
        end
        return TOTAL;
    endfunction

    int r_count, r_pass, r_faddr, r_fexp, r_fgot;

    task automatic run_pass(input logic stop, input bit poke);
        mon_idx  = 0;
        mon_tick = 0;
        seq_bad  = 0;
        busy_cnt = 0;
        done_cnt = 0;
        @(negedge clk);
        mon_en      = 1'b1;
        start       = 1'b1;
        stop_on_err = stop;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 4000; i++) begin
            if (done) break;
            start = (poke && i == 10);
            @(negedge clk);
        end
        start   = 1'b0;
        r_count = int'(read_count);
        r_pass  = int'(pass_ok);
        r_faddr = int'(fail_addr);
        r_fexp  = int'(fail_exp);
        r_fgot  = int'(fail_got);
        @(negedge clk);
        @(negedge clk);
        mon_en = 1'b0;
    endtask

    // Watchdog.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        // Expected order per R2.
        begin
            int k;
            k = 0;
            for (int b = 0; b < N; b++) begin
                exp_seq[k++] = b;
                for (int j = b + 1; j < N; j++) begin
                    exp_seq[k++] = j;
                    exp_seq[k++] = b;
                end
                exp_seq[k++] = b;
            end
        end

        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state, R10 enable idle
        chk("R1", "busy", busy, 0);
        chk("R1", "done", done, 0);
        chk("R10", "ce_n", mem_ce_n, 1);
        chk("R1", "addr", mem_addr, 0);
        chk("R1", "count", read_count, 0);
        chk("R1", "pass_ok", pass_ok, 1);
        chk("R1", "fail_addr", fail_addr, 0);
        chk("R1", "fail_exp", fail_exp, 0);
        chk("R1", "fail_got", fail_got, 0);

        // Clean pass with a start poke during it.
        run_pass(1'b0, 1'b1);
        chk("R4", "clean count", r_count, TOTAL);
        chk("R6", "clean pass", r_pass, 1);
        chk("R2", "order errors", seq_bad, 0);
        chk("R3", "reads seen", mon_idx, TOTAL);
        chk("R5", "busy cycles", busy_cnt, TOTAL * RC + 1);
        chk("R5", "done width", done_cnt, 1);
        chk("R10", "ce_n after", mem_ce_n, 1);

        // Single fault on a partner word, no abort.
        fa_a = 5; fm_a = 4'b0010;
        run_pass(1'b0, 1'b0);
        chk("R9", "count", r_count, TOTAL);
        chk("R6", "pass", r_pass, 0);
        chk("R7", "fail_addr", r_faddr, 5);
        chk("R7", "fail_exp", r_fexp, rom(5));
        chk("R7", "fail_got", r_fgot, rom(5) ^ 4'b0010);
        chk("R2", "order errors", seq_bad, 0);

        // Two faults: word 6 bit 3, word 2 bit 0; word 2 is read first.
        fa_a = 6; fm_a = 4'b1000;
        fa_b = 2; fm_b = 4'b0001;
        run_pass(1'b0, 1'b0);
        chk("R9", "count", r_count, TOTAL);
        chk("R7", "first addr", r_faddr, 2);
        chk("R7", "first got", r_fgot, rom(2) ^ 4'b0001);

        // Abort at word 4.
        fa_a = 4; fm_a = 4'b0100; fa_b = -1;
        run_pass(1'b1, 1'b0);
        chk("R8", "abort count", r_count, first_idx(4) + 1);
        chk("R8", "busy cycles", busy_cnt, (first_idx(4) + 1) * RC + 1);
        chk("R6", "pass", r_pass, 0);
        chk("R2", "order errors", seq_bad, 0);

        // Abort at word 0.
        fa_a = 0; fm_a = 4'b1111;
        run_pass(1'b1, 1'b0);
        chk("R8", "abort count w0", r_count, 1);

        // Abort at top word.
        fa_a = N - 1; fm_a = 4'b1111;
        run_pass(1'b1, 1'b0);
        chk("R8", "abort count top", r_count, first_idx(N - 1) + 1);
        chk("R7", "fail_addr top", r_faddr, N - 1);

        // Clean pass with abort enabled: runs in full, record cleared.
        fa_a = -1;
        run_pass(1'b1, 1'b0);
        chk("R9", "count", r_count, TOTAL);
        chk("R11", "pass", r_pass, 1);
        chk("R11", "fail_addr", r_faddr, 0);
        chk("R11", "fail_exp", r_fexp, 0);
        chk("R11", "fail_got", r_fgot, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule